// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

The filter sits beside a receive MAC and decides whether an incoming frame is kept. It is given the six destination address bytes one at a time as they come off the line. While the bytes arrive it runs a CRC-32 over them. Once the sixth byte is in, it produces a single-cycle verdict. Unicast addresses pass when they equal the programmed station address, or when they hit a 64-bin individual hash table. Multicast addresses pass when they hit a separate 64-bin group hash table. Broadcast has its own reject control, and a promiscuous control lets every frame through.

When promiscuous mode is the only reason a frame passes, a miss flag is raised with the verdict, so that software further up can still filter it. Software sets up the station address, the two hash table pairs and the two control bits through a small write port.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: The hash CRC starts at 32'hFFFFFFFF. Address bytes are fed in arrival order, each least significant bit first. Each bit b updates the register as fb = crc[31]^b, crc = {crc[30:1],crc[0],1'b0} shifted left by one, XOR 32'h04C11DB7 when fb is 1. The hash index is crc[31:26] of the value after 48 bits.
- R2: Index bit 5 picks the upper hash word when 1 and the lower word when 0. Index bits 4:0 pick the bit inside that word. A set bit means a hit.
- R3: A unicast address equal to the station address is accepted whatever the hash contents. The station address is {word 1 bits 15:0, word 0}, and the first received byte is bits 7:0.
- R4: Bit 0 of the first byte marks a group address. A group address that is not broadcast is judged by the group hash only. A unicast address that does not match the station address is judged by the individual hash only.
- R5: The all-ones address is broadcast. It is rejected only when broadcast-reject (control bit 1) is 1 and promiscuous (control bit 0) is 0. Otherwise it is accepted.
- R6: With promiscuous set, every frame is accepted.
- R7: dec_miss is 1 exactly when promiscuous is set and the frame would be rejected with promiscuous clear. It is never 1 without dec_accept.
- R8: dec_vld is high for exactly one cycle, the cycle after the clock edge that captures the sixth byte_vld byte. dec_accept and dec_miss are 0 outside that cycle. Bytes after the sixth are ignored until the next frm_start.
- R9: frm_start discards any partial address and restarts byte counting. A byte presented in the same cycle as frm_start is ignored.
- R10: The write port decodes cfg_addr as follows: 0 station bits 31:0, 1 station bits 47:32, 2/3 individual hash lower/upper, 4/5 group hash lower/upper, 6 control. All of these reset to zero, and dec_vld is 0 in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| frm_start | input | 1 | Start of a new frame |
| byte_vld | input | 1 | byte_in carries an address byte |
| byte_in | input | 8 | Destination address byte |
| dec_vld | output | 1 | Verdict strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_miss | output | 1 | Accepted only because of promiscuous mode |

## Verification
A wrong CRC bit, or a wrong byte count, changes the hash index. This shows up at the very next verdict as an accept where a reject was due, or the reverse. Random addresses against random hash contents make such a flip likely within a few dozen frames. A byte counter that fails to stop or to restart shows as a missing, late or repeated dec_vld within one frame's time. A wrong rule order for broadcast, station or promiscuous shows on the directed frames as a wrong accept or miss value in that same verdict cycle.

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter #(
  parameter int DA_BYTES = 6,
  parameter logic [31:0] POLY = 32'h04C11DB7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        frm_start,
  input  logic        byte_vld,
  input  logic [7:0]  byte_in,
  output logic        dec_vld,
  output logic        dec_accept,
  output logic        dec_miss
);
  localparam int DA_W = DA_BYTES * 8;
  localparam int CW = $clog2(DA_BYTES + 1);
  localparam logic [CW-1:0] LAST = CW'(DA_BYTES - 1);
  localparam logic [CW-1:0] FULL = CW'(DA_BYTES);

  logic [31:0] sta_lo_q, ih_lo_q, ih_hi_q, gh_lo_q, gh_hi_q;
  logic [15:0] sta_hi_q;
  logic        prom_q, bcrej_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_lo_q <= '0; sta_hi_q <= '0;
      ih_lo_q <= '0; ih_hi_q <= '0; gh_lo_q <= '0; gh_hi_q <= '0;
      prom_q <= 1'b0; bcrej_q <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: sta_lo_q <= cfg_wdata;
        3'd1: sta_hi_q <= cfg_wdata[15:0];
        3'd2: ih_lo_q <= cfg_wdata;
        3'd3: ih_hi_q <= cfg_wdata;
        3'd4: gh_lo_q <= cfg_wdata;
        3'd5: gh_hi_q <= cfg_wdata;
        3'd6: begin prom_q <= cfg_wdata[0]; bcrej_q <= cfg_wdata[1]; end
        default: ;
      endcase
    end
  end

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = {r[30:0], 1'b0} ^ ((r[31] ^ b[i]) ? POLY : 32'h0);
    return r;
  endfunction

  logic [CW-1:0] cnt_q;
  logic [DA_W-1:0] da_q;
  logic [31:0] crc_q;
  logic fire_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0; da_q <= '0; crc_q <= '1; fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (frm_start) begin
        cnt_q <= '0; da_q <= '0; crc_q <= '1;
      end else if (byte_vld && cnt_q != FULL) begin
        da_q[{cnt_q, 3'b000} +: 8] <= byte_in;
        crc_q <= crc_step(crc_q, byte_in);
        cnt_q <= cnt_q + 1'b1;
        fire_q <= (cnt_q == LAST);
      end
    end
  end

  wire [5:0]  idx     = crc_q[31:26];
  wire [31:0] ih_word = idx[5] ? ih_hi_q : ih_lo_q;
  wire [31:0] gh_word = idx[5] ? gh_hi_q : gh_lo_q;
  wire        is_bc   = &da_q;
  wire        is_grp  = da_q[0];
  wire        sta_hit = da_q == {sta_hi_q, sta_lo_q};
  wire        normal  = is_bc  ? !bcrej_q :
                        is_grp ? gh_word[idx[4:0]] :
                                 (sta_hit | ih_word[idx[4:0]]);

  assign dec_vld    = fire_q;
  assign dec_accept = fire_q & (normal | prom_q);
  assign dec_miss   = fire_q & prom_q & ~normal;

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |=> !dec_vld);
  a_r8_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_vld) |-> $past(byte_vld && !frm_start));
  a_r7_miss_implies_accept: assert property (@(posedge clk) disable iff (!rst_n)
    dec_miss |-> dec_accept && dec_vld);
  a_r7_miss_needs_prom: assert property (@(posedge clk) disable iff (!rst_n)
    !prom_q |-> !dec_miss);
  a_r6_prom_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && prom_q) |-> dec_accept);
  a_r5_bc_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && is_bc && bcrej_q && !prom_q) |-> !dec_accept);
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> !dec_vld);
endmodule

// File: tb/eth_rx_addr_filter_bench.sv
module eth_rx_addr_filter_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0; logic [2:0] cfg_addr = '0; logic [31:0] cfg_wdata = '0;
  logic frm_start = 1'b0, byte_vld = 1'b0; logic [7:0] byte_in = '0;
  logic dec_vld, dec_accept, dec_miss;

  eth_rx_addr_filter u_eth_rx_addr_filter (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_sta_lo, m_ih_lo, m_ih_hi, m_gh_lo, m_gh_hi;
  logic [15:0] m_sta_hi;
  logic m_prom, m_bcrej;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin n_bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  function automatic logic [5:0] hidx(input logic [47:0] da);
    logic [31:0] c = '1;
    for (int i = 0; i < 48; i++) c = {c[30:0], 1'b0} ^ ((c[31] ^ da[i]) ? 32'h04C11DB7 : 32'h0);
    return c[31:26];
  endfunction

  function automatic logic model_normal(input logic [47:0] da);
    logic [5:0] x = hidx(da);
    logic [31:0] iw = x[5] ? m_ih_hi : m_ih_lo;
    logic [31:0] gw = x[5] ? m_gh_hi : m_gh_lo;
    if (&da) return !m_bcrej;
    if (da[0]) return gw[x[4:0]];
    return (da == {m_sta_hi, m_sta_lo}) || iw[x[4:0]];
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1 cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1 cfg_we = 0;
    case (a)
      3'd0: m_sta_lo = d; 3'd1: m_sta_hi = d[15:0];
      3'd2: m_ih_lo = d;  3'd3: m_ih_hi = d;
      3'd4: m_gh_lo = d;  3'd5: m_gh_hi = d;
      3'd6: begin m_prom = d[0]; m_bcrej = d[1]; end
      default: ;
    endcase
  endtask

  task automatic frame(input logic [47:0] da, input bit gaps, input int extra, input string req);
    logic n; logic ea, em;
    @(posedge clk); #1 frm_start = 1; byte_vld = 1; byte_in = 8'hA5;
    @(posedge clk); #1 frm_start = 0; byte_vld = 0;
    for (int k = 0; k < 6; k++) begin
      if (gaps && $urandom_range(0, 2) == 0) begin @(posedge clk); #1; end
      byte_vld = 1; byte_in = da[8*k +: 8];
      @(negedge clk);
      chk(dec_vld === 1'b0, "R8", 32'(dec_vld), 0);
      @(posedge clk); #1 byte_vld = 0;
    end
    n = model_normal(da);
    ea = n | m_prom; em = m_prom & ~n;
    for (int e = 0; e < extra; e++) begin
      byte_vld = 1; byte_in = 8'($urandom);
      @(negedge clk);
      if (e == 0) begin
        chk(dec_vld === 1'b1, {req, " R8 vld"}, 32'(dec_vld), 1);
        chk(dec_accept === ea, {req, " accept"}, 32'(dec_accept), 32'(ea));
        chk(dec_miss === em, {req, " R7 miss"}, 32'(dec_miss), 32'(em));
      end else chk(dec_vld === 1'b0, "R8 extra byte", 32'(dec_vld), 0);
      @(posedge clk); #1 byte_vld = 0;
    end
    if (extra == 0) begin
      @(negedge clk);
      chk(dec_vld === 1'b1, {req, " R8 vld"}, 32'(dec_vld), 1);
      chk(dec_accept === ea, {req, " accept"}, 32'(dec_accept), 32'(ea));
      chk(dec_miss === em, {req, " R7 miss"}, 32'(dec_miss), 32'(em));
    end
    @(negedge clk);
    chk(dec_vld === 1'b0 && dec_accept === 1'b0, "R8 single", 32'({dec_vld, dec_accept}), 0);
  endtask

  task automatic hset(input bit grp, input logic [47:0] da);
    logic [5:0] x = hidx(da);
    logic [31:0] w = 32'h1 << x[4:0];
    wr(grp ? (x[5] ? 3'd5 : 3'd4) : (x[5] ? 3'd3 : 3'd2), w);
  endtask

  initial begin
    #8_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] ua, ga, sa;
    void'($urandom(32'd2024));
    {m_sta_lo, m_sta_hi, m_ih_lo, m_ih_hi, m_gh_lo, m_gh_hi, m_prom, m_bcrej} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dec_vld === 1'b0, "R10 reset vld", 32'(dec_vld), 0);
    #1 rst_n = 1;
    // R10 reset: zero hashes, zero station -> unicast reject, broadcast accept
    ua = 48'h0A0B0C0D0E10;
    frame(ua, 0, 0, "R10 reset unicast");
    frame('1, 0, 0, "R10 R5 bc default");
    sa = 48'h665544332210;
    wr(0, sa[31:0]); wr(1, {16'h0, sa[47:32]});
    frame(sa, 0, 0, "R3 station");
    frame(sa ^ 48'h100, 0, 0, "R3 near miss");
    hset(0, ua);
    frame(ua, 1, 0, "R1 R2 R4 ihash");
    ga = 48'h0000005E0001;
    frame(ga, 0, 0, "R4 grp no hit via ihash");
    hset(1, ga);
    frame(ga, 0, 0, "R4 ghash hit");
    wr(2, '0); wr(3, '0);
    wr(4, '0); wr(5, '1);
    frame(ga, 0, 0, "R2 upper word");
    wr(4, '1); wr(5, '0);
    frame(ga, 0, 0, "R2 lower word");
    for (int c = 0; c < 4; c++) begin
      wr(6, 32'(c));
      frame('1, 0, 0, "R5 bc combo");
    end
    wr(4, '0); wr(5, '0);
    wr(6, 32'h1);
    frame(ua, 0, 0, "R6 prom unicast");
    frame(sa, 0, 0, "R6 R7 prom station");
    frame(ga, 0, 3, "R6 R8 prom group");
    wr(6, 32'h0);
    // R9: aborted partial frame then restart
    @(posedge clk); #1 frm_start = 1;
    @(posedge clk); #1 frm_start = 0; byte_vld = 1; byte_in = 8'hFF;
    repeat (3) @(posedge clk);
    #1 byte_vld = 0;
    frame(sa, 0, 2, "R9 restart");
    for (int t = 0; t < 300; t++) begin
      logic [47:0] d;
      d = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      if (t % 7 == 0) d = {sa[47:8], sa[7:1], 1'b0};
      if (t % 11 == 0) d = '1;
      if (t % 10 == 0) begin
        wr(3'($urandom_range(2, 5)), $urandom & $urandom);
        wr(6, 32'($urandom_range(0, 3)));
      end
      frame(d, $urandom_range(0, 1) == 1, $urandom_range(0, 2), "R1 R4 R6 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule